// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor that reads and writes single bytes and a main memory that moves whole 32-bit blocks. Every line holds one four-byte block together with its tag, a valid flag, a dirty flag and a recency flag. A request is looked up in both lines of its set at once. A hit completes in the same cycle with no memory traffic. A miss picks a victim line in the set. If that victim holds modified data, the block copies it back to memory first. It then fetches the requested block and finishes the access.

Writes stay in the cache until their line is evicted. A pair of running counters records hits and misses, so a user can measure the hit ratio of a workload. The address width and the number of set-index bits are parameters. The tag takes whatever address bits remain. With a 24-bit address and 13 set bits this gives a 9-bit tag, a 13-bit set index and a 2-bit byte offset. The default build uses fewer sets to keep the storage small.

Top module: `sa2_wb_cache`

## Requirements
- R1: After reset every line is invalid, clean and has its recency flag at 0. Both counters read 0, and `cpu_ready` and `mem_req` are low while no request is pending.
- R2: Address bits [1:0] select the byte in the block. The next SET_W bits select the set, and the remaining upper bits form the tag. The memory block number is the address shifted right by 2.
- R3: A read that hits raises `cpu_ready` in the same cycle as the request. It returns byte k of the block, taken from bits 8k+7..8k, and issues no memory request.
- R4: A lookup compares the tags of both lines in the set at once. A hit needs a valid line with an equal tag, and at most one line of a set can hit.
- R5: On a miss, an invalid line is chosen first, and line 0 is chosen when both lines are invalid. Otherwise the line whose recency flag is 0 is chosen. Each completed access sets the flag of the line it used and clears the flag of the other line in the set.
- R6: On a miss the block reads memory at the requested block number. When `mem_ack` arrives it loads the returned block as valid and clean, and it completes the access in the following cycle.
- R7: A write hit changes only the addressed byte in the cache and marks the line dirty. It does not write memory.
- R8: When the victim is valid and dirty, the block first writes the victim's full block to memory at its own block number (victim tag and set), and only after that does it fetch the new block.
- R9: A clean or invalid victim is replaced without any memory write.
- R10: A write miss fetches the block, merges the new byte into it and leaves the line dirty.
- R11: `hit_count` rises by one for each request that hits on lookup, and `miss_count` rises by one for each request that misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write one byte, 0 = read one byte |
| cpu_addr | input | ADDR_W | Byte address, held during the request |
| cpu_wdata | input | 8 | Byte to write |
| cpu_rdata | output | 8 | Byte read, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back of a block, 0 = block fetch |
| mem_addr | output | ADDR_W-2 | Memory block number |
| mem_wdata | output | 32 | Block being written back |
| mem_rdata | input | 32 | Fetched block, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |
| hit_count | output | 32 | Number of lookup hits |
| miss_count | output | 32 | Number of lookup misses |

## Verification
The bench uses four sets and a 10-bit address. It first reads every byte of the space in order. This separates the first access to a block, which must miss, from the next three accesses, which must hit in the same block, and it fills both lines of each set before any eviction starts. A strided write sweep then maps many blocks onto the same sets. This drives evictions of dirty and clean victims, so that R8 and R9 are told apart by the number of memory writes. A final full read-back shows whether evicted data reached memory intact. A short pattern that alternates three blocks of one set exercises the choice by recency flag. Every outcome of the form hit versus miss is compared with a small bench-side model of tags and flags.

// File: rtl/sa2_wb_cache.sv
module sa2_wb_cache #(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [31:0]       hit_count,
  output logic [31:0]       miss_count
);
  localparam int TAG_W = ADDR_W - SET_W - 2;
  localparam int SETS  = 1 << SET_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FETCH, S_DONE} st_t;
  st_t st;

  logic [31:0]      line_q [2][SETS];
  logic [TAG_W-1:0] tag_q  [2][SETS];
  logic [SETS-1:0]  val_q  [2];
  logic [SETS-1:0]  dty_q  [2];
  logic [SETS-1:0]  use_q  [2];
  logic             vic_q;

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_in;
  logic [1:0]       lane;
  logic [1:0]       hit_w;
  logic             hit, way, vic_c, do_acc, fill;

  assign set_idx = cpu_addr[SET_W+1:2];
  assign tag_in  = cpu_addr[ADDR_W-1:SET_W+2];
  assign lane    = cpu_addr[1:0];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_w[w] = val_q[w][set_idx] && (tag_q[w][set_idx] == tag_in);
  end

  assign hit   = |hit_w;
  assign way   = hit_w[1];
  assign vic_c = !val_q[0][set_idx] ? 1'b0 :
                 !val_q[1][set_idx] ? 1'b1 : use_q[0][set_idx];

  assign do_acc    = cpu_req && ((st == S_IDLE && hit) || st == S_DONE);
  assign fill      = (st == S_FETCH) && mem_ack;
  assign cpu_ready = do_acc;
  assign cpu_rdata = line_q[way][set_idx][8*lane +: 8];

  assign mem_req   = (st == S_WB) || (st == S_FETCH);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_WB) ? {tag_q[vic_q][set_idx], set_idx} : cpu_addr[ADDR_W-1:2];
  assign mem_wdata = line_q[vic_q][set_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      vic_q      <= 1'b0;
      hit_count  <= '0;
      miss_count <= '0;
      for (int w = 0; w < 2; w++) begin
        val_q[w] <= '0;
        dty_q[w] <= '0;
        use_q[w] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          if (hit) hit_count <= hit_count + 32'd1;
          else begin
            miss_count <= miss_count + 32'd1;
            vic_q      <= vic_c;
            st <= (val_q[vic_c][set_idx] && dty_q[vic_c][set_idx]) ? S_WB : S_FETCH;
          end
        end
        S_WB:    if (mem_ack) st <= S_FETCH;
        S_FETCH: if (mem_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
      if (fill) begin
        val_q[vic_q][set_idx] <= 1'b1;
        dty_q[vic_q][set_idx] <= 1'b0;
      end
      if (do_acc) begin
        use_q[way][set_idx]  <= 1'b1;
        use_q[!way][set_idx] <= 1'b0;
        if (cpu_we) dty_q[way][set_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      line_q[vic_q][set_idx] <= mem_rdata;
      tag_q[vic_q][set_idx]  <= tag_in;
    end else if (do_acc && cpu_we) begin
      line_q[way][set_idx][8*lane +: 8] <= cpu_wdata;
    end
  end

  assert_one_way_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_w));
  assert_use_follows_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> use_q[$past(way)][$past(set_idx)] && !use_q[!$past(way)][$past(set_idx)]);
  assert_fill_then_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && cpu_req) |=> (cpu_req && $stable(cpu_addr)) |-> (hit && cpu_ready));
  assert_write_marks_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |=> dty_q[$past(way)][$past(set_idx)]);
  assert_wb_only_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (val_q[vic_q][set_idx] && dty_q[vic_q][set_idx]));
  assert_counts_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_count != $past(hit_count), miss_count != $past(miss_count)}) <= 1);
endmodule

// File: tb/sa2_wb_cache_bench.sv
module sa2_wb_cache_bench;
  localparam int AW = 10;
  localparam int SW = 2;
  localparam int NB = 1 << (AW - 2);

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, mem_req, mem_we, mem_ack = 0;
  logic [AW-3:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0, hit_count, miss_count;

  sa2_wb_cache #(.ADDR_W(AW), .SET_W(SW)) u_sa2_wb_cache (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_ready,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack, .hit_count, .miss_count);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0, wb_seen = 0, mem_cnt = 0;
  logic [31:0] mem [NB];
  logic [7:0]  ref_b [1 << AW];
  logic [AW-SW-3:0] mtag [2][1 << SW];
  logic mval [2][1 << SW], mdty [2][1 << SW], muse [2][1 << SW];
  int exp_hits = 0, exp_miss = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_ack) begin
      mem_ack <= 0; mem_cnt <= 0;
    end else if (mem_req) begin
      if (mem_cnt == 2) begin
        mem_ack <= 1;
        if (mem_we) begin mem[mem_addr] <= mem_wdata; wb_seen <= wb_seen + 1; end
        else mem_rdata <= mem[mem_addr];
      end else mem_cnt <= mem_cnt + 1;
    end
  end

  initial begin
    wait (cycles >= 190000);
    errors++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [7:0] d);
    int s, w, v, lat, wb0;
    bit eh, ewb;
    logic [AW-SW-3:0] t;
    logic [7:0] got;
    s = int'(a[SW+1:2]); t = a[AW-1:SW+2];
    eh = 0; w = 0;
    for (int k = 0; k < 2; k++) if (mval[k][s] && mtag[k][s] == t) begin eh = 1; w = k; end
    ewb = 0;
    if (!eh) begin
      v = !mval[0][s] ? 0 : !mval[1][s] ? 1 : (muse[0][s] ? 1 : 0);
      ewb = mval[v][s] && mdty[v][s];
      mval[v][s] = 1; mdty[v][s] = 0; mtag[v][s] = t; w = v;
      exp_miss++;
    end else exp_hits++;
    muse[w][s] = 1; muse[1-w][s] = 0;
    if (we) mdty[w][s] = 1;
    wb0 = wb_seen;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1; lat = 0;
    while (!cpu_ready) begin @(negedge clk); #1; lat++; end
    got = cpu_rdata;
    @(posedge clk); #1 cpu_req = 0;
    // R4 R5 R6: hit or miss outcome against the bench model
    chk((lat == 0) == eh, "R4/R5/R6 hit outcome", lat == 0, eh);
    // R8 R9: one write-back only for a dirty victim
    chk((wb_seen - wb0) == (ewb ? 1 : 0), "R8/R9 write-back count", wb_seen - wb0, ewb);
    if (!we) chk(got == ref_b[a], "R3/R6 read byte", got, ref_b[a]);
    else ref_b[a] = d;
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      mem[b] = {8'(b*4+3), 8'(b*4+2), 8'(b*4+1), 8'(b*4)} ^ 32'hA55A_3CC3;
      for (int k = 0; k < 4; k++) ref_b[b*4+k] = mem[b][8*k +: 8];
    end
    for (int s = 0; s < (1 << SW); s++)
      for (int k = 0; k < 2; k++) begin mval[k][s] = 0; mdty[k][s] = 0; muse[k][s] = 0; mtag[k][s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(hit_count == 0 && miss_count == 0, "R1 counters", hit_count, 0);
    chk(!cpu_ready && !mem_req, "R1 idle outputs", {cpu_ready, mem_req}, 0);
    // R1 R2 R3 R6: sequential read of every byte
    for (int a = 0; a < (1 << AW); a++) access(0, AW'(a), 8'h00);
    // R7 R8 R9 R10: strided writes map many blocks onto the same sets
    for (int i = 0; i < 300; i++) access(1, AW'((i * 37) % (1 << AW)), 8'(i ^ 8'h5A));
    // R5: three blocks of set 1 in a rotating pattern, with write hits between
    for (int r = 0; r < 12; r++) begin
      access(0, AW'(16'h004 + 16'h010 * (r % 3)), 8'h00);
      access(1, AW'(16'h005 + 16'h010 * (r % 3)), 8'(r));
    end
    // R2 R3 R8: read back everything, including data that went to memory
    for (int a = 0; a < (1 << AW); a++) access(0, AW'(a), 8'h00);
    @(negedge clk);
    // R11: counters
    chk(hit_count == 32'(exp_hits), "R11 hit_count", hit_count, exp_hits);
    chk(miss_count == 32'(exp_miss), "R11 miss_count", miss_count, exp_miss);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule